// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a register-mapped mailbox between a host processor and a power-management microcontroller. The host talks to it over a simple 32-bit register bus. It has a command register, a status register, two pointer registers, and two 16-byte data buffers: one the host writes, one the host reads.

Writing the command register while the mailbox is idle does three things. It latches the command word, sets busy, and sends a one-cycle doorbell to the service side. The service side reads the command, the pointers and the host's payload through its own port. It then fills the result buffer and posts a one-cycle done strobe, which carries an error flag and an 8-bit error code.

The done strobe clears busy and loads the error state. If the command asked for a completion interrupt, the strobe also sets an interrupt-pending flag. That flag drives the host interrupt output until the host acknowledges it through the status register. Commands that do not ask for an interrupt are completed by polling the status register.

Top module: `ipc_mailbox_top`

## Requirements
- R1: After reset, the status word, both pointers, the latched command, the doorbell and the interrupt output are all zero.
- R2: A write to the command register (offset 0x00) while not busy latches the word on `svc_cmd_o` and sets status bit 0 (busy) on the next cycle. In that same next cycle, `svc_doorbell_o` is high, for exactly one cycle.
- R3: A write to the command register while busy is ignored: no doorbell, the latched command is unchanged, and busy stays set.
- R4: A done strobe while busy clears busy on the next cycle. It loads status bit 1 with the error flag, and status bits [23:16] with the error code if the flag is set, or zero if it is not. Codes 0 to 7 are none, not supported, not serviced, unable to service, invalid, failed, security rejection and unsigned-image rejection. Codes of 8 and above are passed through unchanged, with the error bit set. A done strobe while idle has no effect.
- R5: If bit 8 of the latched command is set, a done strobe sets status bit 2 (interrupt pending), and `irq_o` follows that bit. If bit 8 is clear, completion changes neither `irq_o` nor bit 2.
- R6: A write to the status register (offset 0x04) with bit 2 set clears interrupt pending. A status write with bit 2 clear leaves it unchanged.
- R7: An accepted command clears the error bit and the error code.
- R8: The host writes the four payload words at offsets 0x80, 0x84, 0x88 and 0x8C. The service side reads word i through `svc_wbuf_idx_i` = i.
- R9: The service side writes result word i through `svc_rbuf_idx_i` = i. The host reads it back at offset 0x90 + 4*i.
- R10: The source pointer (0x08) and destination pointer (0x0C) are read/write from the host and drive `svc_sptr_o` and `svc_dptr_o`. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_req_i | input | 1 | Host access strobe |
| hst_we_i | input | 1 | Host write enable (with hst_req_i) |
| hst_addr_i | input | ADDR_W | Host byte offset |
| hst_wdata_i | input | 32 | Host write data |
| hst_rdata_o | output | 32 | Host read data, combinational from hst_addr_i |
| irq_o | output | 1 | Completion interrupt (interrupt-pending flag) |
| svc_doorbell_o | output | 1 | One-cycle new-command pulse |
| svc_cmd_o | output | 32 | Latched command word |
| svc_sptr_o | output | 32 | Source pointer |
| svc_dptr_o | output | 32 | Destination pointer |
| svc_wbuf_idx_i | input | IDX_W | Payload word index |
| svc_wbuf_data_o | output | 32 | Payload word at that index |
| svc_rbuf_we_i | input | 1 | Result word write enable |
| svc_rbuf_idx_i | input | IDX_W | Result word index |
| svc_rbuf_data_i | input | 32 | Result word data |
| svc_done_i | input | 1 | One-cycle completion strobe |
| svc_err_i | input | 1 | Completion error flag |
| svc_code_i | input | 8 | Completion error code |

## Verification
The bench builds the block with its defaults: an 8-bit offset space and four buffer words. With these settings, both 16-byte buffers sit at their fixed offsets and every word index can be reached from both sides. The vector table drives commands with and without the interrupt request. It covers clean completions, codes inside and outside the defined range, and a code that must be masked when no error is flagged. Directed tests then cover the busy-write drop, a done strobe while idle, acknowledge with and without bit 2, and error clearing on the next command.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CODE_W = 8;

  localparam logic [7:0] OFF_CMD  = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h04;
  localparam logic [7:0] OFF_SPTR = 8'h08;
  localparam logic [7:0] OFF_DPTR = 8'h0C;
  localparam logic [7:0] OFF_WBUF = 8'h80;
  localparam logic [7:0] OFF_RBUF = 8'h90;

  localparam int unsigned CMD_IRQ_BIT   = 8;
  localparam int unsigned STAT_BUSY     = 0;
  localparam int unsigned STAT_ERR      = 1;
  localparam int unsigned STAT_IRQ      = 2;
  localparam int unsigned STAT_CODE_LSB = 16;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CMD, SEL_STAT, SEL_SPTR, SEL_DPTR, SEL_WBUF, SEL_RBUF
  } sel_e;

  typedef struct packed {
    logic              busy;
    logic              err;
    logic              irq;
    logic [CODE_W-1:0] code;
  } stat_t;

  function automatic logic [WORD_W-1:0] pack_stat(stat_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[STAT_BUSY] = s.busy;
    w[STAT_ERR]  = s.err;
    w[STAT_IRQ]  = s.irq;
    w[STAT_CODE_LSB +: CODE_W] = s.code;
    return w;
  endfunction
endpackage

// File: rtl/ipc_mbx_decode.sv
module ipc_mbx_decode
  import ipc_mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BUF_WORDS = 4,
  localparam int unsigned IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned BUF_BYTES = 4 * BUF_WORDS;

  logic [ADDR_W-1:0] hi_bits;
  logic [7:0]        lo;
  logic [7:0]        w_rel;
  logic [7:0]        r_rel;
  logic              in_range;

  assign hi_bits  = addr_i >> 8;
  assign lo       = addr_i[7:0];
  assign in_range = (hi_bits == '0);
  assign w_rel    = lo - OFF_WBUF;
  assign r_rel    = lo - OFF_RBUF;

  always_comb begin
    sel_o = SEL_NONE;
    idx_o = '0;
    if (in_range) begin
      if ({lo[7:2], 2'b00} == OFF_CMD)       sel_o = SEL_CMD;
      else if ({lo[7:2], 2'b00} == OFF_STAT) sel_o = SEL_STAT;
      else if ({lo[7:2], 2'b00} == OFF_SPTR) sel_o = SEL_SPTR;
      else if ({lo[7:2], 2'b00} == OFF_DPTR) sel_o = SEL_DPTR;
      else if (lo >= OFF_WBUF && 32'(w_rel) < BUF_BYTES) begin
        sel_o = SEL_WBUF;
        idx_o = w_rel[2 +: IDX_W];
      end else if (lo >= OFF_RBUF && 32'(r_rel) < BUF_BYTES) begin
        sel_o = SEL_RBUF;
        idx_o = r_rel[2 +: IDX_W];
      end
    end
  end
endmodule

// File: rtl/ipc_mbx_store.sv
module ipc_mbx_store
  import ipc_mbx_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 4,
  localparam int unsigned IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sptr_we_i,
  input  logic              dptr_we_i,
  input  logic              wbuf_we_i,
  input  logic [IDX_W-1:0]  hst_idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] sptr_o,
  output logic [WORD_W-1:0] dptr_o,
  output logic [WORD_W-1:0] hst_rbuf_o,
  input  logic [IDX_W-1:0]  svc_widx_i,
  output logic [WORD_W-1:0] svc_wbuf_o,
  input  logic              svc_rbuf_we_i,
  input  logic [IDX_W-1:0]  svc_ridx_i,
  input  logic [WORD_W-1:0] svc_rdata_i
);
  logic [WORD_W-1:0] wbuf_q [BUF_WORDS];
  logic [WORD_W-1:0] rbuf_q [BUF_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sptr_o <= '0;
      dptr_o <= '0;
    end else begin
      if (sptr_we_i) sptr_o <= wdata_i;
      if (dptr_we_i) dptr_o <= wdata_i;
    end
  end

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wbuf_q[g] <= '0;
        rbuf_q[g] <= '0;
      end else begin
        if (wbuf_we_i && hst_idx_i == IDX_W'(g))      wbuf_q[g] <= wdata_i;
        if (svc_rbuf_we_i && svc_ridx_i == IDX_W'(g)) rbuf_q[g] <= svc_rdata_i;
      end
    end
  end

  assign svc_wbuf_o = wbuf_q[svc_widx_i];
  assign hst_rbuf_o = rbuf_q[hst_idx_i];
endmodule

// File: rtl/ipc_mbx_ctrl.sv
module ipc_mbx_ctrl
  import ipc_mbx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              stat_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic              err_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [WORD_W-1:0] cmd_o,
  output logic              doorbell_o,
  output stat_t             stat_o
);
  logic              busy_q, err_q, irq_q, bell_q;
  logic [CODE_W-1:0] code_q;
  logic [WORD_W-1:0] cmd_q;
  logic              accept, finish;

  assign accept = cmd_we_i && !busy_q;
  assign finish = done_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
      irq_q  <= 1'b0;
      bell_q <= 1'b0;
    end else begin
      bell_q <= accept;
      if (accept) begin
        cmd_q  <= wdata_i;
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        code_q <= '0;
      end
      if (finish) begin
        busy_q <= 1'b0;
        err_q  <= err_i;
        code_q <= err_i ? code_i : '0;
      end
      // completion set has priority over a same-cycle acknowledge
      if (stat_we_i && wdata_i[STAT_IRQ]) irq_q <= 1'b0;
      if (finish && cmd_q[CMD_IRQ_BIT])   irq_q <= 1'b1;
    end
  end

  assign cmd_o       = cmd_q;
  assign doorbell_o  = bell_q;
  assign stat_o.busy = busy_q;
  assign stat_o.err  = err_q;
  assign stat_o.irq  = irq_q;
  assign stat_o.code = code_q;
endmodule

// File: rtl/ipc_mailbox_top.sv
module ipc_mailbox_top
  import ipc_mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BUF_WORDS = 4,
  localparam int unsigned IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hst_req_i,
  input  logic              hst_we_i,
  input  logic [ADDR_W-1:0] hst_addr_i,
  input  logic [31:0]       hst_wdata_i,
  output logic [31:0]       hst_rdata_o,
  output logic              irq_o,
  output logic              svc_doorbell_o,
  output logic [31:0]       svc_cmd_o,
  output logic [31:0]       svc_sptr_o,
  output logic [31:0]       svc_dptr_o,
  input  logic [IDX_W-1:0]  svc_wbuf_idx_i,
  output logic [31:0]       svc_wbuf_data_o,
  input  logic              svc_rbuf_we_i,
  input  logic [IDX_W-1:0]  svc_rbuf_idx_i,
  input  logic [31:0]       svc_rbuf_data_i,
  input  logic              svc_done_i,
  input  logic              svc_err_i,
  input  logic [7:0]        svc_code_i
);
  sel_e              sel_w;
  logic [IDX_W-1:0]  idx_w;
  logic              wr_w;
  logic              cmd_we_w, stat_we_w;
  stat_t             stat_w;
  logic [WORD_W-1:0] rbuf_w;

  assign wr_w      = hst_req_i && hst_we_i;
  assign cmd_we_w  = wr_w && sel_w == SEL_CMD;
  assign stat_we_w = wr_w && sel_w == SEL_STAT;

  ipc_mbx_decode #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) u_dec (
    .addr_i (hst_addr_i),
    .sel_o  (sel_w),
    .idx_o  (idx_w)
  );

  ipc_mbx_store #(.BUF_WORDS(BUF_WORDS)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sptr_we_i     (wr_w && sel_w == SEL_SPTR),
    .dptr_we_i     (wr_w && sel_w == SEL_DPTR),
    .wbuf_we_i     (wr_w && sel_w == SEL_WBUF),
    .hst_idx_i     (idx_w),
    .wdata_i       (hst_wdata_i),
    .sptr_o        (svc_sptr_o),
    .dptr_o        (svc_dptr_o),
    .hst_rbuf_o    (rbuf_w),
    .svc_widx_i    (svc_wbuf_idx_i),
    .svc_wbuf_o    (svc_wbuf_data_o),
    .svc_rbuf_we_i (svc_rbuf_we_i),
    .svc_ridx_i    (svc_rbuf_idx_i),
    .svc_rdata_i   (svc_rbuf_data_i)
  );

  ipc_mbx_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (cmd_we_w),
    .stat_we_i  (stat_we_w),
    .wdata_i    (hst_wdata_i),
    .done_i     (svc_done_i),
    .err_i      (svc_err_i),
    .code_i     (svc_code_i),
    .cmd_o      (svc_cmd_o),
    .doorbell_o (svc_doorbell_o),
    .stat_o     (stat_w)
  );

  assign irq_o = stat_w.irq;

  always_comb begin
    unique case (sel_w)
      SEL_CMD:  hst_rdata_o = svc_cmd_o;
      SEL_STAT: hst_rdata_o = pack_stat(stat_w);
      SEL_SPTR: hst_rdata_o = svc_sptr_o;
      SEL_DPTR: hst_rdata_o = svc_dptr_o;
      SEL_RBUF: hst_rdata_o = rbuf_w;
      default:  hst_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ipc_mbx_chk.sv
module ipc_mbx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_wr_i,
  input logic        stat_wr_i,
  input logic [31:0] wdata_i,
  input logic        busy_i,
  input logic        done_i,
  input logic        doorbell_i,
  input logic        irq_i,
  input logic [31:0] cmd_i
);
  a_r2_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && !busy_i |=> doorbell_i && busy_i && cmd_i == $past(wdata_i));

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doorbell_i |=> !doorbell_i);

  a_r3_busy_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && busy_i |=> !doorbell_i && $stable(cmd_i));

  a_r4_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && done_i |=> !busy_i);

  a_r5_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && done_i && cmd_i[8] |=> irq_i);

  a_r5_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && done_i && !cmd_i[8] && !irq_i |=> !irq_i);

  a_r6_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && wdata_i[2] && !(busy_i && done_i) |=> !irq_i);
endmodule

bind ipc_mailbox_top ipc_mbx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_wr_i   (cmd_we_w),
  .stat_wr_i  (stat_we_w),
  .wdata_i    (hst_wdata_i),
  .busy_i     (stat_w.busy),
  .done_i     (svc_done_i),
  .doorbell_i (svc_doorbell_o),
  .irq_i      (irq_o),
  .cmd_i      (svc_cmd_o)
);

// File: tb/ipc_mailbox_top_test.sv
module ipc_mailbox_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, bell;
  logic [31:0] cmd, sptr, dptr, wbuf_data;
  logic [1:0]  widx = '0, ridx = '0;
  logic        rbuf_we = 1'b0;
  logic [31:0] rbuf_data = '0;
  logic        done = 1'b0, err = 1'b0;
  logic [7:0]  code = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ipc_mailbox_top uut (
    .clk_i(clk), .rst_ni(rst_n), .hst_req_i(req), .hst_we_i(we),
    .hst_addr_i(addr), .hst_wdata_i(wdata), .hst_rdata_o(rdata), .irq_o(irq),
    .svc_doorbell_o(bell), .svc_cmd_o(cmd), .svc_sptr_o(sptr), .svc_dptr_o(dptr),
    .svc_wbuf_idx_i(widx), .svc_wbuf_data_o(wbuf_data), .svc_rbuf_we_i(rbuf_we),
    .svc_rbuf_idx_i(ridx), .svc_rbuf_data_i(rbuf_data), .svc_done_i(done),
    .svc_err_i(err), .svc_code_i(code)
  );

  typedef struct packed {
    logic [31:0] cmd;
    logic        err;
    logic [7:0]  code;
    logic [31:0] stat;
    logic        irq;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h0000_0105, 1'b0, 8'h00, 32'h0000_0004, 1'b1},
    '{32'h0010_2007, 1'b1, 8'h03, 32'h0003_0002, 1'b0},
    '{32'h0000_11AA, 1'b1, 8'h07, 32'h0007_0006, 1'b1},
    '{32'h0004_0001, 1'b1, 8'hC8, 32'h00C8_0002, 1'b0},
    '{32'h0000_0100, 1'b0, 8'h55, 32'h0000_0004, 1'b1}
  };

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic finish_cmd(logic e, logic [7:0] c);
    @(negedge clk);
    done = 1'b1; err = e; code = c;
    @(negedge clk);
    done = 1'b0; err = 1'b0; code = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h04, d); check("R1 status", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 doorbell", {31'b0, bell}, 32'h0);
    check("R1 cmd", cmd, 32'h0);
    check("R1 sptr", sptr, 32'h0);

    // vector table: R2 R4 R5 R6
    foreach (VECS[i]) begin
      wr(8'h00, VECS[i].cmd);
      check("R2 doorbell high", {31'b0, bell}, 32'h1);
      check("R2 cmd latched", cmd, VECS[i].cmd);
      rd(8'h04, d);
      check("R2 busy", d, 32'h1);
      check("R2 doorbell one cycle", {31'b0, bell}, 32'h0);
      finish_cmd(VECS[i].err, VECS[i].code);
      rd(8'h04, d);
      check("R4 R5 status", d, VECS[i].stat);
      check("R5 irq", {31'b0, irq}, {31'b0, VECS[i].irq});
      wr(8'h04, 32'h4);
      check("R6 ack", {31'b0, irq}, 32'h0);
    end

    // R3 write while busy
    wr(8'h00, 32'h0000_0111);
    wr(8'h00, 32'h0000_0022);
    check("R3 no doorbell", {31'b0, bell}, 32'h0);
    check("R3 cmd kept", cmd, 32'h0000_0111);
    rd(8'h04, d); check("R3 still busy", d, 32'h1);
    finish_cmd(1'b1, 8'h05);
    rd(8'h04, d); check("R4 error done", d, 32'h0005_0006);

    // R6 write without bit 2 keeps pending
    wr(8'h04, 32'hFFFF_FFFB);
    check("R6 no ack", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h4);
    check("R6 ack", {31'b0, irq}, 32'h0);

    // R4 done while idle ignored
    finish_cmd(1'b1, 8'h09);
    rd(8'h04, d); check("R4 idle done", d, 32'h0005_0002);

    // R7 new command clears error
    wr(8'h00, 32'h0000_0003);
    rd(8'h04, d); check("R7 error cleared", d, 32'h1);
    finish_cmd(1'b0, 8'h00);
    rd(8'h04, d); check("R7 clean", d, 32'h0);
    check("R5 no irq polled", {31'b0, irq}, 32'h0);

    // R8 payload buffer
    for (int k = 0; k < 4; k++) wr(8'h80 + 8'(4 * k), 32'hA000_0000 + 32'(k));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); widx = 2'(k);
      #1 check("R8 payload word", wbuf_data, 32'hA000_0000 + 32'(k));
    end

    // R9 result buffer
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); rbuf_we = 1'b1; ridx = 2'(k); rbuf_data = 32'h5B00_0010 + 32'(k);
    end
    @(negedge clk); rbuf_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      rd(8'h90 + 8'(4 * k), d);
      check("R9 result word", d, 32'h5B00_0010 + 32'(k));
    end

    // R10 pointers and unmapped
    wr(8'h08, 32'h1234_5678);
    wr(8'h0C, 32'h9ABC_DEF0);
    check("R10 sptr out", sptr, 32'h1234_5678);
    check("R10 dptr out", dptr, 32'h9ABC_DEF0);
    rd(8'h08, d); check("R10 sptr read", d, 32'h1234_5678);
    rd(8'h0C, d); check("R10 dptr read", d, 32'h9ABC_DEF0);
    rd(8'h40, d); check("R10 unmapped", d, 32'h0);
    rd(8'hA0, d); check("R10 past buffers", d, 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule